// File: doc/BRIEF.md
# Compressed Branch Cycle Counter

This block measures how many clock cycles pass between two successive taken-branch events and hands the result on in a compact 14-bit floating-point-like code. A saturating counter runs between events. When a branch strobe is sampled, the current count is compressed into an exponent and mantissa pair, registered together with an "unknown" flag, and announced by a one-cycle valid pulse. Counting then starts again.

Large counts lose their low-order bits: the code keeps the eight bits just below the leading one, and the leading one itself is implicit. Counts that reach the counter's ceiling give a dedicated all-ones code. The unknown flag marks records whose interval cannot be trusted. This covers the first record after reset, and any interval during which the count-valid qualifier dropped.

A separate combinational decode path turns a code back into a 32-bit integer. Software-side interpretation of the records can therefore be checked against the same rules.

Top module: `branch_cycle_codec`

## Requirements
- R1: A branch strobe sampled high at a clock edge makes `rec_valid_o` high for exactly the following cycle. With no strobe at an edge, `rec_valid_o` is low in the following cycle.
- R2: The count carried by a record equals the number of clock edges from the previous branch edge to this one. Strobes on back-to-back edges give a count of 1. The first interval after reset starts with a count of 1 at the first edge after reset release.
- R3: A count below 256 is encoded with exponent field `rec_code_o[13:8]` = 0 and mantissa field `rec_code_o[7:0]` equal to the count.
- R4: A count c from 256 up to the ceiling is encoded with E = p - 7, where p is the bit index of the leading one of c. M holds bits p-1 down to p-8 of c. The lower bits are dropped, which truncates toward zero.
- R5: The counter stops at 2^CNT_W - 1 instead of wrapping. A record taken at that count carries code 0x3FFF. Below that count the encoder never emits an exponent above CNT_W - 8.
- R6: The first record after reset has `rec_unknown_o` = 1.
- R7: `rec_unknown_o` is 1 when `cnt_valid_i` was sampled low at any edge of the interval, including the branch edge itself. Otherwise it is 0.
- R8: With `dec_unknown_i` low, the decoder gives M for E = 0, and (256 + M) shifted left by E - 1 for E > 0.
- R9: The decoder gives all ones for code 0x3FFF. It also gives all ones for any code whose expanded value would not fit in 32 bits (E > 24).
- R10: With `dec_unknown_i` high, the decoder output is zero whatever the code.
- R11: While reset is asserted, `rec_valid_o`, `rec_code_o` and `rec_unknown_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| branch_i | input | 1 | Taken-branch event strobe |
| cnt_valid_i | input | 1 | Qualifier; low marks the current interval's count as untrustworthy |
| rec_valid_o | output | 1 | One-cycle pulse announcing a new record |
| rec_code_o | output | 14 | Compressed count: exponent in [13:8], mantissa in [7:0] |
| rec_unknown_o | output | 1 | Record's count is unknown |
| dec_code_i | input | 14 | Code to expand |
| dec_unknown_i | input | 1 | Unknown flag accompanying the code to expand |
| dec_count_o | output | 32 | Expanded count |

## Verification
Some checks run on every cycle. The assertions watch the valid pulse following each strobe, the count of 1 for back-to-back strobes, the unknown flag after reset and after a low qualifier at the branch edge, and the exponent bound for non-saturated codes. They also watch the three decoder rules: zero when unknown, all ones for the overflow code, and the plain mantissa at exponent zero.

Other behaviour depends on long intervals, so only the directed scenarios can show it. This includes the exact mantissa and exponent chosen for counts at each power-of-two boundary, saturation after thousands of idle cycles, and a qualifier dip in the middle of an interval. The scenarios also decode each record and compare the result with the true count truncated to the code's resolution.

// File: rtl/branch_cycle_codec.sv
module branch_cycle_codec #(
  parameter int CNT_W = 16,
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             branch_i,
  input  logic             cnt_valid_i,
  output logic             rec_valid_o,
  output logic [13:0]      rec_code_o,
  output logic             rec_unknown_o,
  input  logic [13:0]      dec_code_i,
  input  logic             dec_unknown_i,
  output logic [DEC_W-1:0] dec_count_o
);
  localparam int              IDX_W    = $clog2(CNT_W);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [13:0]     OVF_CODE = '1;
  localparam logic [5:0]      DEC_EMAX = 6'(DEC_W - 8);

  logic [CNT_W-1:0] cnt;
  logic             unk_pend;
  logic [IDX_W-1:0] top;
  logic [CNT_W-1:0] norm;
  logic [13:0]      enc_code;

  always_comb begin
    top = '0;
    for (int i = 0; i < CNT_W; i++)
      if (cnt[i]) top = IDX_W'(i);
  end

  assign norm = cnt >> (top - IDX_W'(8));

  always_comb begin
    if (cnt == CNT_SAT)
      enc_code = OVF_CODE;
    else if (cnt[CNT_W-1:8] == '0)
      enc_code = {6'd0, cnt[7:0]};
    else
      enc_code = {6'(top) - 6'd7, norm[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= CNT_W'(1);
      unk_pend      <= 1'b1;
      rec_valid_o   <= 1'b0;
      rec_code_o    <= '0;
      rec_unknown_o <= 1'b0;
    end else begin
      rec_valid_o <= branch_i;
      if (branch_i) begin
        rec_code_o    <= enc_code;
        rec_unknown_o <= unk_pend | ~cnt_valid_i;
        unk_pend      <= 1'b0;
        cnt           <= CNT_W'(1);
      end else begin
        if (!cnt_valid_i) unk_pend <= 1'b1;
        if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
      end
    end
  end

  logic [5:0] dec_e;
  logic [7:0] dec_m;
  assign dec_e = dec_code_i[13:8];
  assign dec_m = dec_code_i[7:0];

  always_comb begin
    if (dec_unknown_i)
      dec_count_o = '0;
    else if (dec_code_i == OVF_CODE)
      dec_count_o = '1;
    else if (dec_e == 6'd0)
      dec_count_o = DEC_W'(dec_m);
    else if (dec_e > DEC_EMAX)
      dec_count_o = '1;
    else
      dec_count_o = DEC_W'({1'b1, dec_m}) << (dec_e - 6'd1);
  end
endmodule

// File: rtl/branch_cycle_codec_chk.sv
module branch_cycle_codec_chk #(
  parameter int CNT_W = 16,
  parameter int DEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             branch_i,
  input logic             cnt_valid_i,
  input logic             rec_valid_o,
  input logic [13:0]      rec_code_o,
  input logic             rec_unknown_o,
  input logic [13:0]      dec_code_i,
  input logic             dec_unknown_i,
  input logic [DEC_W-1:0] dec_count_o
);
  logic prev_branch;
  logic seen_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_branch <= 1'b0;
      seen_rec    <= 1'b0;
    end else begin
      prev_branch <= branch_i;
      if (rec_valid_o) seen_rec <= 1'b1;
    end
  end

  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    branch_i |=> rec_valid_o);
  p_no_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_i |=> !rec_valid_o);
  p_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_i && prev_branch) |=> (rec_code_o == 14'd1));
  p_exp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_code_o != 14'h3FFF) |-> (int'(rec_code_o[13:8]) <= CNT_W - 8));
  p_first_unknown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !seen_rec) |-> rec_unknown_o);
  p_qual_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_i && !cnt_valid_i) |=> rec_unknown_o);
  p_dec_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_unknown_i && dec_code_i[13:8] == 6'd0) |-> (dec_count_o == DEC_W'(dec_code_i[7:0])));
  p_dec_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_unknown_i && dec_code_i == 14'h3FFF) |-> (dec_count_o == '1));
  p_dec_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_unknown_i |-> (dec_count_o == '0));
endmodule

bind branch_cycle_codec branch_cycle_codec_chk #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .branch_i(branch_i), .cnt_valid_i(cnt_valid_i),
  .rec_valid_o(rec_valid_o), .rec_code_o(rec_code_o), .rec_unknown_o(rec_unknown_o),
  .dec_code_i(dec_code_i), .dec_unknown_i(dec_unknown_i), .dec_count_o(dec_count_o)
);

// File: tb/test_branch_cycle_codec.sv
module test_branch_cycle_codec;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 14;
  localparam longint SATV = (64'd1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        branch_i = 1'b0;
  logic        cnt_valid_i = 1'b1;
  logic        rec_valid_o;
  logic [13:0] rec_code_o;
  logic        rec_unknown_o;
  logic [13:0] dec_code_i = '0;
  logic        dec_unknown_i = 1'b0;
  logic [31:0] dec_count_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_cycle_codec #(.CNT_W(CW), .DEC_W(32)) i_branch_cycle_codec (
    .clk(clk), .rst_n(rst_n), .branch_i(branch_i), .cnt_valid_i(cnt_valid_i),
    .rec_valid_o(rec_valid_o), .rec_code_o(rec_code_o), .rec_unknown_o(rec_unknown_o),
    .dec_code_i(dec_code_i), .dec_unknown_i(dec_unknown_i), .dec_count_o(dec_count_o)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_of(longint c);
    int e = 1;
    if (c < 256) return 0;
    while (c >= (longint'(512) << (e - 1))) e++;
    return e;
  endfunction

  function automatic logic [13:0] model_code(longint c);
    int e;
    if (c >= SATV) return 14'h3FFF;
    e = exp_of(c);
    if (e == 0) return 14'(c);
    return {6'(e), 8'((c >> (e - 1)) - 256)};
  endfunction

  function automatic longint model_dec(logic [13:0] code);
    longint v;
    if (code == 14'h3FFF) return 64'hFFFF_FFFF;
    if (code[13:8] == 0) return longint'(code[7:0]);
    v = longint'({1'b1, code[7:0]}) << (code[13:8] - 1);
    if (v > 64'hFFFF_FFFF) return 64'hFFFF_FFFF;
    return v;
  endfunction

  task automatic run_interval(int n, int low_at, bit exp_unk, string req);
    longint tr;
    int e;
    for (int i = 1; i <= n; i++) begin
      branch_i = (i == n);
      cnt_valid_i = (i != low_at);
      @(negedge clk);
      if (i == 1 && n > 1) check(rec_valid_o == 1'b0, "R1 idle", rec_valid_o, 0);
    end
    branch_i = 1'b0;
    cnt_valid_i = 1'b1;
    check(rec_valid_o == 1'b1, "R1 pulse", rec_valid_o, 1);
    check(rec_code_o == model_code(n), req, rec_code_o, model_code(n));
    check(rec_unknown_o == exp_unk, "R6/R7 unknown", rec_unknown_o, exp_unk);
    if (n < SATV) begin
      e = exp_of(n);
      tr = (e == 0) ? n : ((longint'(n) >> (e - 1)) << (e - 1));
      dec_code_i = rec_code_o;
      dec_unknown_i = 1'b0;
      #1;
      check(dec_count_o == 32'(tr), "R8 roundtrip", dec_count_o, tr);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    branch_i = 1'b1;
    cnt_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    check(rec_valid_o == 0 && rec_code_o == 0 && rec_unknown_o == 0, "R11 reset",
          {rec_valid_o, rec_code_o, rec_unknown_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first();
    run_interval(5, 0, 1'b1, "R2 R6 first");
  endtask

  task automatic t_small();
    run_interval(1, 0, 1'b0, "R2 back-to-back");
    run_interval(1, 0, 1'b0, "R2 back-to-back");
    run_interval(2, 0, 1'b0, "R3 small");
    run_interval(37, 0, 1'b0, "R3 small");
    run_interval(255, 0, 1'b0, "R3 top of plain range");
  endtask

  task automatic t_large();
    run_interval(256, 0, 1'b0, "R4 e1 low");
    run_interval(257, 0, 1'b0, "R4 e1");
    run_interval(511, 0, 1'b0, "R4 e1 high");
    run_interval(512, 0, 1'b0, "R4 e2 low");
    run_interval(1001, 0, 1'b0, "R4 truncation");
    run_interval(4097, 0, 1'b0, "R4 truncation");
    run_interval(9000, 0, 1'b0, "R4 large");
  endtask

  task automatic t_qual();
    run_interval(50, 20, 1'b1, "R7 dip mid");
    run_interval(20, 0, 1'b0, "R7 clean after");
    run_interval(30, 30, 1'b1, "R7 dip at branch");
    run_interval(10, 1, 1'b1, "R7 dip first edge");
    run_interval(10, 0, 1'b0, "R7 clean");
  endtask

  task automatic t_sat();
    run_interval(int'(SATV) - 1, 0, 1'b0, "R5 below ceiling");
    run_interval(int'(SATV), 0, 1'b0, "R5 ceiling");
    run_interval(20000, 0, 1'b0, "R5 held");
    run_interval(3, 0, 1'b0, "R5 restart");
  endtask

  task automatic dec_one(logic [13:0] code, bit unk, string req);
    longint exp;
    dec_code_i = code;
    dec_unknown_i = unk;
    #1;
    exp = unk ? 0 : model_dec(code);
    check(dec_count_o == 32'(exp), req, dec_count_o, exp);
  endtask

  task automatic t_decode();
    dec_one(14'h0000, 1'b0, "R8 zero");
    dec_one(14'h00FF, 1'b0, "R8 plain");
    dec_one(14'h0100, 1'b0, "R8 e1");
    dec_one(14'h0105, 1'b0, "R8 e1 m5");
    dec_one(14'h0201, 1'b0, "R8 e2");
    dec_one(14'h18FF, 1'b0, "R8 e24 max");
    dec_one(14'h1900, 1'b0, "R9 too wide");
    dec_one(14'h3FFF, 1'b0, "R9 overflow code");
    dec_one(14'h0105, 1'b1, "R10 unknown");
    dec_one(14'h3FFF, 1'b1, "R10 unknown ovf");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first();
    t_small();
    t_large();
    t_qual();
    t_sat();
    t_decode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule